// File: doc/BRIEF.md
# Vector Length Set Unit

This block carries out a set-vector-length operation for a scalar pipeline. Each request brings a requested length as an immediate, the index and value of a source register, and a destination register index. The unit picks a new vector length (VL) from a short chain of unsigned comparisons, stores it in its own VL register and returns it as a write-back to the destination register.

If the immediate exceeds the register width XLEN, the unit raises a trap flag in place of a result. VL is not a plain minimum. When the source value is above the immediate but no more than twice it, VL is half the source value. When the source value is more than twice the immediate, VL is the full XLEN. A source index of zero selects the immediate directly.

Every request is answered one cycle later by a one-cycle done pulse. The trap flag, the write enable and the result are valid in that same cycle.

Top module: `vl_set_unit`

## Requirements
- R1: A request whose immediate is greater than XLEN gives trap=1 with done. In that case vl_out does not change and wb_en stays 0.
- R2: If the immediate is at most XLEN and the source index is 0, the new VL equals the immediate.
- R3: Otherwise, if the source value is strictly greater than twice the immediate (an unsigned compare that cannot overflow), the new VL is XLEN.
- R4: Otherwise, if the source value is strictly greater than the immediate, the new VL is the source value shifted right by one bit (the floor of half).
- R5: In all remaining cases the new VL equals the source value.
- R6: The trap check comes before the source-index-zero rule. A too-large immediate with source index 0 therefore still traps.
- R7: On a non-trapping request with a nonzero destination index, wb_en=1, wb_idx is the destination index and wb_data is the new VL zero-extended to XLEN bits. wb_data equals vl_out in that cycle.
- R8: When the destination index is 0, wb_en stays 0 but vl_out still takes the new VL.
- R9: done, trap, wb_en and the new vl_out appear exactly one cycle after req_valid. done is a single-cycle pulse per request. In a cycle after req_valid=0, done, trap and wb_en are 0 and vl_out holds its value.
- R10: After reset, vl_out=0 and done, trap and wb_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_imm | input | IMM_W | Requested length immediate |
| req_src_idx | input | IDX_W | Source register index |
| req_src_val | input | XLEN | Source register value |
| req_dst_idx | input | IDX_W | Destination register index |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Illegal immediate, valid with done |
| vl_out | output | VL_W | Current VL register |
| wb_en | output | 1 | Register-file write enable |
| wb_idx | output | IDX_W | Register-file write index |
| wb_data | output | XLEN | Register-file write data |

## Verification
The bench keeps its own model of VL and compares it after every request. A VL register that took a wrong value, or changed on a trap or on an idle cycle, appears on vl_out in the cycle after the request. Every later write-back also carries the error. The same vl_out comparison in the following idle cycle catches a wrong priority between the rules, or a doubling compare that overflows. Directed corner cases sit on each comparison boundary, including a source value exactly equal to twice the immediate, and are mixed with seeded random requests.

// File: rtl/vl_set_unit.sv
module vl_set_unit #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 7,
  parameter int IDX_W = 5,
  parameter int VL_W  = $clog2(XLEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IMM_W-1:0] req_imm,
  input  logic [IDX_W-1:0] req_src_idx,
  input  logic [XLEN-1:0]  req_src_val,
  input  logic [IDX_W-1:0] req_dst_idx,
  output logic             done,
  output logic             trap,
  output logic [VL_W-1:0]  vl_out,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]  wb_data
);
  localparam int CW = (XLEN > IMM_W ? XLEN : IMM_W) + 2;

  logic [CW-1:0]   src_x, imm_x, imm_dbl;
  logic            bad_imm;
  logic [VL_W-1:0] next_vl;

  assign src_x   = CW'(req_src_val);
  assign imm_x   = CW'(req_imm);
  assign imm_dbl = imm_x << 1;
  assign bad_imm = imm_x > CW'(XLEN);

  always_comb begin
    if (req_src_idx == '0)
      next_vl = VL_W'(imm_x);
    else if (src_x > imm_dbl)
      next_vl = VL_W'(XLEN);
    else if (src_x > imm_x)
      next_vl = VL_W'(src_x >> 1);
    else
      next_vl = VL_W'(src_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      trap    <= 1'b0;
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      wb_data <= '0;
      vl_out  <= '0;
    end else begin
      done  <= req_valid;
      trap  <= req_valid && bad_imm;
      wb_en <= req_valid && !bad_imm && (req_dst_idx != '0);
      if (req_valid && !bad_imm) begin
        vl_out  <= next_vl;
        wb_idx  <= req_dst_idx;
        wb_data <= XLEN'(next_vl);
      end
    end
  end
endmodule

module vl_set_unit_chk #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 7,
  parameter int IDX_W = 5,
  parameter int VL_W  = $clog2(XLEN + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [IMM_W-1:0] req_imm,
  input logic [IDX_W-1:0] req_src_idx,
  input logic [XLEN-1:0]  req_src_val,
  input logic [IDX_W-1:0] req_dst_idx,
  input logic             done,
  input logic             trap,
  input logic [VL_W-1:0]  vl_out,
  input logic             wb_en,
  input logic [IDX_W-1:0] wb_idx,
  input logic [XLEN-1:0]  wb_data
);
  logic big_imm;
  assign big_imm = 32'(req_imm) > XLEN;

  // R1
  trap_holds_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && big_imm |=> trap && done && !wb_en && $stable(vl_out));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !done && !trap && !wb_en && $stable(vl_out));

  // R9
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> done);

  // R7
  wb_matches_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done && !trap && wb_idx != '0 && wb_data == XLEN'(vl_out));

  // R8
  no_wb_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_dst_idx == '0 |=> !wb_en);

  // R3
  vl_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(vl_out) <= XLEN);
endmodule

bind vl_set_unit vl_set_unit_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W), .VL_W(VL_W)) u_chk (.*);

// File: tb/tb_vl_set_unit.sv
module tb_vl_set_unit;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN  = 64;
  localparam int IMM_W = 7;
  localparam int IDX_W = 5;
  localparam int VL_W  = $clog2(XLEN + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic [IMM_W-1:0] req_imm = '0;
  logic [IDX_W-1:0] req_src_idx = '0;
  logic [XLEN-1:0]  req_src_val = '0;
  logic [IDX_W-1:0] req_dst_idx = '0;
  logic             done, trap, wb_en;
  logic [VL_W-1:0]  vl_out;
  logic [IDX_W-1:0] wb_idx;
  logic [XLEN-1:0]  wb_data;

  int errors = 0;
  int checks = 0;
  longint unsigned model_vl = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vl_set_unit #(.XLEN(XLEN), .IMM_W(IMM_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_imm(req_imm),
    .req_src_idx(req_src_idx), .req_src_val(req_src_val), .req_dst_idx(req_dst_idx),
    .done(done), .trap(trap), .vl_out(vl_out), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data));

  function automatic longint unsigned pick_vl(input int imm, input int sidx,
                                              input longint unsigned sval);
    longint unsigned dbl = 2 * longint'(imm);
    if (sidx == 0) return longint'(imm);
    if (sval > dbl) return XLEN;
    if (sval > longint'(imm)) return sval / 2;
    return sval;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input int imm, input int sidx, input longint unsigned sval,
                        input int didx, input string req);
    bit exp_trap = imm > XLEN;
    longint unsigned old_vl = model_vl;
    @(negedge clk);
    req_valid = 1'b1; req_imm = IMM_W'(imm); req_src_idx = IDX_W'(sidx);
    req_src_val = sval; req_dst_idx = IDX_W'(didx);
    @(negedge clk);
    req_valid = 1'b0;
    if (!exp_trap) model_vl = pick_vl(imm, sidx, sval);
    chk(done == 1'b1, {req, "/R9 done"}, done, 1);
    chk(trap == exp_trap, {req, "/R1 trap"}, trap, exp_trap);
    chk(longint'(vl_out) == model_vl, {req, " vl"}, vl_out, model_vl);
    if (exp_trap) begin
      chk(longint'(vl_out) == old_vl, "R1 vl held on trap", vl_out, old_vl);
      chk(!wb_en, "R1 no wb on trap", wb_en, 0);
    end else if (didx == 0) begin
      chk(!wb_en, "R8 no wb to index 0", wb_en, 0);
    end else begin
      chk(wb_en && wb_idx == IDX_W'(didx), "R7 wb idx", wb_idx, didx);
      chk(wb_data == model_vl, "R7 wb data", wb_data, model_vl);
    end
    @(negedge clk);
    chk(!done && !trap && !wb_en, "R9 idle quiet", {done, trap, wb_en}, 0);
    chk(longint'(vl_out) == model_vl, "R9 vl holds", vl_out, model_vl);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7031));
    repeat (3) @(negedge clk);
    chk(vl_out == '0 && !done && !trap && !wb_en, "R10 reset state", vl_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vl_out == '0 && !done, "R10 after release", vl_out, 0);

    run_op(5, 0, 64'd999, 3, "R2");
    run_op(0, 0, 64'd7, 4, "R2 zero imm");
    run_op(70, 0, 64'd1, 5, "R6");
    run_op(65, 2, 64'd3, 5, "R1");
    run_op(10, 1, 64'd21, 6, "R3");
    run_op(10, 1, 64'd20, 6, "R4 at 2*imm");
    run_op(10, 1, 64'd11, 6, "R4");
    run_op(10, 1, 64'd10, 6, "R5 at imm");
    run_op(10, 1, 64'd3, 6, "R5");
    run_op(0, 7, 64'd1, 8, "R3 zero imm");
    run_op(64, 7, 64'hFFFF_FFFF_FFFF_FFFF, 8, "R3 max src");
    run_op(64, 7, 64'd128, 8, "R4 max imm");
    run_op(9, 3, 64'd13, 0, "R8");
    run_op(127, 3, 64'd13, 9, "R1 max imm");

    for (int i = 0; i < 400; i++) begin
      int imm = $urandom_range(0, 80);
      int sidx = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 31);
      int didx = ($urandom_range(0, 5) == 0) ? 0 : $urandom_range(1, 31);
      longint unsigned sval;
      case ($urandom_range(0, 2))
        0: sval = longint'($urandom_range(0, 200));
        1: sval = longint'(imm) + longint'($urandom_range(0, 2)) + longint'(imm);
        default: sval = {$urandom, $urandom};
      endcase
      run_op(imm, sidx, sval, didx, "R2-R5 random");
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule